// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two signed two's complement operands of `N` bits each and returns their full `2N`-bit signed product. It works serially. When a start request arrives while the unit is idle, it takes both operands in the same clock edge. It then spends exactly `N` cycles on the multiply, doing one recoded step per cycle. In each step it adds, subtracts or skips the multiplicand, and then shifts its working register right by one place.

The working state has three parts: an accumulator, a shift register that holds the multiplier, and a one-bit extension below that register. In each step, the lowest multiplier bit and the extension bit together select the operation. The accumulator carries one guard bit above `N`. The guard bit keeps the most negative multiplicand exact: subtracting it cannot wrap inside the accumulator.

A one-cycle `done_o` pulse marks the end of a multiply. The product is read from the output bus. It stays unchanged until the next accepted start. A start request that arrives during a multiply is dropped.

Top module: `booth_mul`

## Requirements
- R1: After reset, `busy_o` is 0, `done_o` is 0 and `product_o` is all zeros.
- R2: A start request (`start_i` = 1) seen at a clock edge while `busy_o` is 0 samples both operands at that edge, and `busy_o` is 1 from the next cycle on.
- R3: `busy_o` stays 1 for exactly `N` cycles. `done_o` is then 1 for exactly one cycle, and `busy_o` is 0 during that cycle.
- R4: While `done_o` is 1, `product_o` equals the `2N`-bit two's complement product of the two sampled operands, with the multiplicand in `multiplicand_i` and the multiplier in `multiplier_i`.
- R5: The recoding of each step is driven by the pair {multiplier LSB, extension bit}. The pair 2'b10 subtracts the multiplicand, 2'b01 adds it, and 2'b00 or 2'b11 leave the accumulator unchanged. The extension bit starts at 0. As a result, every operand pair, including runs of ones in the multiplier, gives the exact product.
- R6: Each step shifts {accumulator, multiplier register, extension bit} right by one place, copying the sign bit into the top. As a result, products with mixed operand signs are negative and exact.
- R7: Operands equal to -2^(N-1) give exact products, for example -128 × -128 = 16384 with N = 8. Any carry out of the guarded accumulator sum is dropped.
- R8: A start request seen while `busy_o` is 1 is ignored. The current multiply keeps its operands, its product and its `N`-cycle length.
- R9: After `done_o`, `product_o` keeps its value in every cycle until the next accepted start, whatever the operand inputs do.
- R10: With N = 4, multiplicand 4'b0110 (+6) times multiplier 4'b1101 (-3) gives `product_o` = 8'b1110_1110 (-18).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a multiply; honoured only while idle |
| multiplicand_i | input | N | Signed multiplicand, sampled when a start is accepted |
| multiplier_i | input | N | Signed multiplier, sampled when a start is accepted |
| busy_o | output | 1 | High while the multiply steps run |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| product_o | output | 2N | Signed product |

## Verification
The bench builds two copies of the block. The first uses N = 8 and receives seeded random operands plus directed corners at -128, +127, 0 and -1; it carries the guard-bit cases of R7. The second uses N = 4, where the whole space of 256 operand pairs is small enough to run exhaustively. That sweep exercises every recoding pattern of R5, every sign combination of R6, and the worked example of R10. Some multiplies are run with start requests and changing operands during the busy window, to show that such requests are ignored.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        STEP_SKIP = 2'd0,
        STEP_ADD  = 2'd1,
        STEP_SUB  = 2'd2
    } step_op_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic     q_lsb,
    input  logic     q_ext,
    output step_op_e op
);
    always_comb begin
        unique case ({q_lsb, q_ext})
            2'b10:   op = STEP_SUB;
            2'b01:   op = STEP_ADD;
            default: op = STEP_SKIP;
        endcase
    end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N:0]   acc,
    input  logic [N-1:0] mcand,
    input  step_op_e     op,
    output logic [N:0]   sum
);
    logic [N:0] mcand_ext;

    assign mcand_ext = {mcand[N-1], mcand};

    always_comb begin
        unique case (op)
            STEP_ADD: sum = acc + mcand_ext;
            STEP_SUB: sum = acc - mcand_ext;
            default:  sum = acc;
        endcase
    end
endmodule

// File: rtl/booth_shift.sv
module booth_shift #(
    parameter int N = 8
) (
    input  logic [N:0]   sum,
    input  logic [N-1:0] mq,
    output logic [N:0]   acc_nx,
    output logic [N-1:0] mq_nx,
    output logic         ext_nx
);
    assign acc_nx = {sum[N], sum[N:1]};
    assign mq_nx  = {sum[0], mq[N-1:1]};
    assign ext_nx = mq[0];
endmodule

// File: rtl/booth_mul.sv
module booth_mul
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [N-1:0]   multiplicand_i,
    input  logic [N-1:0]   multiplier_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*N-1:0] product_o
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST_STEP = CW'(N - 1);

    typedef struct packed {
        logic [N:0]    acc;
        logic [N-1:0]  mq;
        logic          ext;
        logic [N-1:0]  mcand;
        logic [CW-1:0] cnt;
        logic          busy;
        logic          done;
    } state_t;

    state_t   st_d, st_q;
    step_op_e op;
    logic [N:0]   sum;
    logic [N:0]   acc_nx;
    logic [N-1:0] mq_nx;
    logic         ext_nx;

    booth_recode u_recode (
        .q_lsb (st_q.mq[0]),
        .q_ext (st_q.ext),
        .op    (op)
    );

    booth_addsub #(.N(N)) u_addsub (
        .acc   (st_q.acc),
        .mcand (st_q.mcand),
        .op    (op),
        .sum   (sum)
    );

    booth_shift #(.N(N)) u_shift (
        .sum    (sum),
        .mq     (st_q.mq),
        .acc_nx (acc_nx),
        .mq_nx  (mq_nx),
        .ext_nx (ext_nx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.acc   = '0;
                st_d.mq    = multiplier_i;
                st_d.ext   = 1'b0;
                st_d.mcand = multiplicand_i;
                st_d.cnt   = '0;
                st_d.busy  = 1'b1;
            end
        end else begin
            st_d.acc = acc_nx;
            st_d.mq  = mq_nx;
            st_d.ext = ext_nx;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_STEP) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o    = st_q.busy;
    assign done_o    = st_q.done;
    assign product_o = {st_q.acc[N-1:0], st_q.mq};
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic [N-1:0]   multiplicand_i,
    input logic [N-1:0]   multiplier_i,
    input logic           busy_o,
    input logic           done_o,
    input logic [2*N-1:0] product_o
);
    localparam int RW = $clog2(N + 1) + 1;

    logic [N-1:0]   cap_m, cap_q;
    logic [RW-1:0]  run_cnt;
    logic [2*N-1:0] ref_prod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_m   <= '0;
            cap_q   <= '0;
            run_cnt <= '0;
        end else if (start_i && !busy_o) begin
            cap_m   <= multiplicand_i;
            cap_q   <= multiplier_i;
            run_cnt <= '0;
        end else if (busy_o) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign ref_prod = {{N{cap_m[N-1]}}, cap_m} * {{N{cap_q[N-1]}}, cap_q};

    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_cnt == RW'(N)));

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_product_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (product_o == ref_prod));

    p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(product_o));
endmodule

bind booth_mul booth_mul_chk #(.N(N)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .multiplicand_i (multiplicand_i),
    .multiplier_i   (multiplier_i),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .product_o      (product_o)
);

// File: tb/sim_booth_mul.sv
module sim_booth_mul;
    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic        st8 = 1'b0, st4 = 1'b0;
    logic [7:0]  m8 = '0, q8 = '0;
    logic [3:0]  m4 = '0, q4 = '0;
    logic        busy8, done8, busy4, done4;
    logic [15:0] p8;
    logic [7:0]  p4;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    booth_mul #(.N(8)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(st8),
        .multiplicand_i(m8), .multiplier_i(q8),
        .busy_o(busy8), .done_o(done8), .product_o(p8)
    );

    booth_mul #(.N(4)) u1 (
        .clk(clk), .rst_n(rst_n), .start_i(st4),
        .multiplicand_i(m4), .multiplier_i(q4),
        .busy_o(busy4), .done_o(done4), .product_o(p4)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_mul(input int a, input int b);
        return 16'(a * b);
    endfunction

    function automatic logic cur_busy(input bit nar);
        return nar ? busy4 : busy8;
    endfunction

    function automatic logic cur_done(input bit nar);
        return nar ? done4 : done8;
    endfunction

    function automatic logic [15:0] cur_prod(input bit nar);
        return nar ? {8'h00, p4} : p8;
    endfunction

    // One full multiply; operands are signed integers in range of the chosen width.
    task automatic run_case(input bit nar, input int a, input int b, input bit hammer, input string req);
        logic [15:0] e, got;
        int busy_seen, guard, width;
        width = nar ? 4 : 8;
        e = ref_mul(a, b);
        if (nar) e = {8'h00, e[7:0]};
        if (nar) begin m4 = a[3:0]; q4 = b[3:0]; st4 = 1'b1; end
        else     begin m8 = a[7:0]; q8 = b[7:0]; st8 = 1'b1; end
        @(negedge clk);
        st4 = 1'b0; st8 = 1'b0;
        chk(cur_busy(nar) == 1'b1, "R2 busy after start", 16'(cur_busy(nar)), 16'd1);
        busy_seen = 0;
        guard = 0;
        while (!cur_done(nar) && guard < 100) begin
            if (cur_busy(nar)) busy_seen++;
            if (hammer && cur_busy(nar)) begin
                // R8: requests and new operands during the busy window
                if (nar) begin st4 = 1'b1; m4 = ~m4; q4 = q4 + 4'd3; end
                else     begin st8 = 1'b1; m8 = ~m8; q8 = q8 + 8'd37; end
            end
            @(negedge clk);
            guard++;
        end
        st4 = 1'b0; st8 = 1'b0;
        chk(busy_seen == width, hammer ? "R8 busy length" : "R3 busy length", 16'(busy_seen), 16'(width));
        chk(!cur_busy(nar), "R3 idle at done", 16'(cur_busy(nar)), 16'd0);
        got = cur_prod(nar);
        chk(got == e, req, got, e);
        // R9: change operands while idle, product must hold
        if (nar) begin m4 = 4'h5; q4 = 4'h9; end else begin m8 = 8'h5A; q8 = 8'hC3; end
        @(negedge clk);
        chk(cur_done(nar) == 1'b0, "R3 done pulse width", 16'(cur_done(nar)), 16'd0);
        chk(cur_prod(nar) == got, "R9 product hold", cur_prod(nar), got);
    endtask

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        @(negedge clk);
        chk(busy8 == 1'b0 && done8 == 1'b0, "R1 flags in reset", {busy8, done8}, 16'd0);
        chk(p8 == 16'd0 && p4 == 8'd0, "R1 product in reset", p8, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: worked 4-bit example, explicit bit pattern
        run_case(1'b1, 6, -3, 1'b0, "R10 6 x -3");
        chk(p4 == 8'b1110_1110, "R10 bit pattern", {8'h00, p4}, 16'h00EE);

        // R7: most negative and extreme operands
        run_case(1'b0, -128, -128, 1'b0, "R7 -128 x -128");
        run_case(1'b0, -128, 127, 1'b0, "R7 -128 x 127");
        run_case(1'b0, 127, -128, 1'b0, "R7 127 x -128");
        run_case(1'b0, 127, 127, 1'b0, "R7 127 x 127");
        run_case(1'b0, 0, -128, 1'b0, "R7 0 x -128");
        run_case(1'b0, -1, -1, 1'b0, "R6 -1 x -1");
        run_case(1'b1, -8, -8, 1'b0, "R7 -8 x -8");

        // R5: runs of ones in the multiplier
        run_case(1'b0, 37, 8'sb0111_1110, 1'b0, "R5 run of ones");
        run_case(1'b0, -51, 8'sb0101_0101, 1'b0, "R5 alternating bits");

        // R8: requests during busy are ignored
        run_case(1'b0, -77, 93, 1'b1, "R8 product with busy starts");
        run_case(1'b1, 5, -7, 1'b1, "R8 narrow busy starts");

        // R5 R6: exhaustive 4-bit sweep
        for (int a = -8; a < 8; a++) begin
            for (int b = -8; b < 8; b++) begin
                run_case(1'b1, a, b, 1'b0, (a < 0) != (b < 0) ? "R6 mixed signs" : "R5 recoding");
            end
        end

        // R4: seeded random 8-bit operands
        for (int i = 0; i < 300; i++) begin
            logic [7:0] ra, rb;
            ra = 8'($urandom);
            rb = 8'($urandom);
            run_case(1'b0, int'($signed(ra)), int'($signed(rb)), (i % 7) == 0, "R4 random product");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule